// File: doc/BRIEF.md
# Server Power Sequencer

This block presses a simulated front-panel power button towards the chipset to turn a server on or off. It then watches the power-good input to confirm that the transition happened. A power-up press lasts until power-good rises or a long window expires. A power-down press lasts until power-good falls or a shorter window expires. If the window expires before power-good confirms, the block sets a fault flag for that direction. The flag stays set until software clears it.

The block also conditions its inputs and gates its outputs:
- The physical power button is debounced before it is passed to the chipset.
- The sleep-state (S5) line is qualified by a hold time, and each qualified change produces a one-cycle event.
- The power-on-enable output is held low after reset until the controller reports that its initialization is done.
- A secure-mode input blocks the button drive entirely.

All time windows are counted in units. One unit is a fixed number of `tick_i` pulses. The defaults give 1 ms units with 8000/2000/50/15-unit windows. A bench can shrink these through parameters.

Controller states, with their `state_o` codes:
- WAIT_INIT (0): after reset.
- IDLE (1).
- PRESS_ON (2).
- PRESS_OFF (3).

State transitions:
- WAIT_INIT→IDLE when the init-done input is high.
- IDLE→PRESS_ON on a power-on request. This has priority when both requests are high.
- IDLE→PRESS_OFF on a power-off request.
- PRESS_ON→IDLE on power-good high, or on the up-window timeout (which sets the up fault).
- PRESS_OFF→IDLE on power-good low, or on the down-window timeout (which sets the down fault).

Top module: `pwr_seq_top`

## Requirements
- R1: After reset `pwr_en_o` is 0 and `state_o` is 0. One cycle after `init_done_i` is seen high, `pwr_en_o` becomes 1 and `state_o` becomes 1. `pwr_en_o` then stays 1 until reset, whatever `init_done_i` does.
- R2: In IDLE, a power-on request moves `state_o` to 2 on the next edge and drives `chip_btn_o` to 1. The press holds until `pwr_good_i` is seen high, and one edge later `state_o` is 1 and the drive is released.
- R3: If `pwr_good_i` stays low for UP_UNITS units of PRESS_ON, the block returns to IDLE and `fault_up_o` becomes 1.
- R4: In IDLE, a power-off request moves `state_o` to 3 and drives `chip_btn_o` to 1. The press holds until `pwr_good_i` is seen low, then the block returns to IDLE.
- R5: If `pwr_good_i` stays high for DN_UNITS units of PRESS_OFF, the block returns to IDLE and `fault_dn_o` becomes 1.
- R6: Requests are ignored while `pwr_en_o` is 0 and while a press is in progress.
- R7: A fault flag stays 1 until `fault_clr_i` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R8: `btn_raw_i` counts as pressed only after it holds a level for BTN_UNITS units; shorter pulses have no effect. The qualified level drives `chip_btn_o`, but it never starts a timed press.
- R9: While `secure_i` is 1, `chip_btn_o` is 0, both for button presses and for sequencer presses.
- R10: `s5_o` takes the level of `s5_raw_i` only after that level has held for S5_UNITS units. It resets to 0.
- R11: Each change of `s5_o` produces exactly one one-cycle pulse on `s5_evt_o`.
- R12: Units advance only on `tick_i` pulses, with one unit per TICK_DIV pulses. With `tick_i` held low, no window expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick pulse |
| init_done_i | input | 1 | Controller initialization finished |
| secure_i | input | 1 | Secure-mode lockout of the button drive |
| pwr_good_i | input | 1 | System power-good |
| btn_raw_i | input | 1 | Raw physical power button |
| s5_raw_i | input | 1 | Raw sleep-state S5 line |
| req_on_i | input | 1 | Power-on request |
| req_off_i | input | 1 | Power-off request |
| fault_clr_i | input | 1 | Clear both fault flags |
| chip_btn_o | output | 1 | Button drive towards chipset |
| pwr_en_o | output | 1 | Power-on enable |
| fault_up_o | output | 1 | Power-up confirmation fault |
| fault_dn_o | output | 1 | Power-down confirmation fault |
| s5_o | output | 1 | Qualified S5 level |
| s5_evt_o | output | 1 | One-cycle S5 change event |
| state_o | output | 2 | Sequencer state code |

## Verification
The hardest behaviour to observe is a press that ends by timeout rather than by power-good. It must be shown both that the timeout does not fire early and that it does fire. The stimulus starts a press with power-good held at the wrong level and samples at a point safely inside the window and again after it. It also repeats the press with ticks stopped, which shows that only units advance the window. A second press request during a running press is injected mid-window to show that it is ignored. Debounce glitches are sized just below the hold time.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        S_WAIT_INIT = 2'd0,
        S_IDLE      = 2'd1,
        S_PRESS_ON  = 2'd2,
        S_PRESS_OFF = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pwr_timebase.sv
module pwr_timebase #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic unit_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign unit_o = tick_i && (cnt_q == LAST);

    assert_div_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST)
        else $error("tick divider out of range");

endmodule

// File: rtl/pwr_level_qual.sv
module pwr_level_qual #(
    parameter int   HOLD_UNITS = 50,
    parameter logic RST_VAL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unit_i,
    input  logic raw_i,
    output logic level_o,
    output logic chg_o
);
    localparam int HW = $clog2(HOLD_UNITS + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_UNITS - 1);

    logic [1:0]    sync_q;
    logic [HW-1:0] cnt_q;
    logic          level_q;
    logic          chg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= {2{RST_VAL}};
            cnt_q   <= '0;
            level_q <= RST_VAL;
            chg_q   <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            chg_q  <= 1'b0;
            if (sync_q[1] != level_q) begin
                if (unit_i) begin
                    if (cnt_q == LAST) begin
                        level_q <= sync_q[1];
                        cnt_q   <= '0;
                        chg_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign level_o = level_q;
    assign chg_o   = chg_q;

    assert_level_on_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_i |=> $stable(level_o))
        else $error("qualified level moved without a unit strobe");

    assert_evt_with_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_o) |-> (level_o != $past(level_o)))
        else $error("change event without level change");

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int UP_UNITS = 8000,
    parameter int DN_UNITS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unit_i,
    input  logic       init_done_i,
    input  logic       pwr_good_i,
    input  logic       req_on_i,
    input  logic       req_off_i,
    input  logic       fault_clr_i,
    output seq_state_e state_o,
    output logic       press_o,
    output logic       pwr_en_o,
    output logic       fault_up_o,
    output logic       fault_dn_o
);
    localparam int MAXU = (UP_UNITS > DN_UNITS) ? UP_UNITS : DN_UNITS;
    localparam int TW   = $clog2(MAXU + 1);
    localparam logic [TW-1:0] UP_LAST = TW'(UP_UNITS - 1);
    localparam logic [TW-1:0] DN_LAST = TW'(DN_UNITS - 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic          up_tmo, dn_tmo;
    logic          up_fail, dn_fail;
    logic          fault_up_q, fault_dn_q;

    assign up_tmo  = (state_q == S_PRESS_ON)  && unit_i && (tmr_q == UP_LAST);
    assign dn_tmo  = (state_q == S_PRESS_OFF) && unit_i && (tmr_q == DN_LAST);
    assign up_fail = up_tmo && !pwr_good_i;
    assign dn_fail = dn_tmo &&  pwr_good_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_INIT: if (init_done_i) state_d = S_IDLE;
            S_IDLE: begin
                if (req_on_i)       state_d = S_PRESS_ON;
                else if (req_off_i) state_d = S_PRESS_OFF;
            end
            S_PRESS_ON:  if (pwr_good_i || up_tmo)  state_d = S_IDLE;
            S_PRESS_OFF: if (!pwr_good_i || dn_tmo) state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_WAIT_INIT;
        else        state_q <= state_d;
    end

    // press window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (state_d != state_q ||
                     !(state_q == S_PRESS_ON || state_q == S_PRESS_OFF)) begin
            tmr_q <= '0;
        end else if (unit_i) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // output process: sticky fault flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_up_q <= 1'b0;
            fault_dn_q <= 1'b0;
        end else begin
            if (up_fail)          fault_up_q <= 1'b1;
            else if (fault_clr_i) fault_up_q <= 1'b0;
            if (dn_fail)          fault_dn_q <= 1'b1;
            else if (fault_clr_i) fault_dn_q <= 1'b0;
        end
    end

    assign state_o    = state_q;
    assign press_o    = (state_q == S_PRESS_ON) || (state_q == S_PRESS_OFF);
    assign pwr_en_o   = (state_q != S_WAIT_INIT);
    assign fault_up_o = fault_up_q;
    assign fault_dn_o = fault_dn_q;

    assert_en_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_o |=> pwr_en_o)
        else $error("enable dropped");

    assert_up_fault_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_up_o) |-> ($past(state_q) == S_PRESS_ON && !$past(pwr_good_i)))
        else $error("up fault outside a failed power-up");

    assert_dn_fault_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_dn_o) |-> ($past(state_q) == S_PRESS_OFF && $past(pwr_good_i)))
        else $error("down fault outside a failed power-down");

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRESS_ON && !pwr_good_i && !unit_i) |=> (state_q == S_PRESS_ON))
        else $error("power-up press left without cause");

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_up_o && !fault_clr_i) |=> fault_up_o)
        else $error("up fault cleared without request");

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int TICK_DIV  = 1,
    parameter int UP_UNITS  = 8000,
    parameter int DN_UNITS  = 2000,
    parameter int BTN_UNITS = 50,
    parameter int S5_UNITS  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       init_done_i,
    input  logic       secure_i,
    input  logic       pwr_good_i,
    input  logic       btn_raw_i,
    input  logic       s5_raw_i,
    input  logic       req_on_i,
    input  logic       req_off_i,
    input  logic       fault_clr_i,
    output logic       chip_btn_o,
    output logic       pwr_en_o,
    output logic       fault_up_o,
    output logic       fault_dn_o,
    output logic       s5_o,
    output logic       s5_evt_o,
    output logic [1:0] state_o
);
    logic       unit;
    logic       btn_lvl;
    logic       btn_chg_unused;
    logic       seq_press;
    seq_state_e st;

    pwr_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .unit_o(unit)
    );

    pwr_level_qual #(.HOLD_UNITS(BTN_UNITS), .RST_VAL(1'b0)) u_btn_q (
        .clk(clk), .rst_n(rst_n), .unit_i(unit), .raw_i(btn_raw_i),
        .level_o(btn_lvl), .chg_o(btn_chg_unused)
    );

    pwr_level_qual #(.HOLD_UNITS(S5_UNITS), .RST_VAL(1'b0)) u_s5_q (
        .clk(clk), .rst_n(rst_n), .unit_i(unit), .raw_i(s5_raw_i),
        .level_o(s5_o), .chg_o(s5_evt_o)
    );

    pwr_seq_fsm #(.UP_UNITS(UP_UNITS), .DN_UNITS(DN_UNITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .unit_i(unit),
        .init_done_i(init_done_i), .pwr_good_i(pwr_good_i),
        .req_on_i(req_on_i), .req_off_i(req_off_i), .fault_clr_i(fault_clr_i),
        .state_o(st), .press_o(seq_press), .pwr_en_o(pwr_en_o),
        .fault_up_o(fault_up_o), .fault_dn_o(fault_dn_o)
    );

    assign chip_btn_o = (seq_press || btn_lvl) && !secure_i;
    assign state_o    = st;

    assert_btn_no_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(btn_lvl) && st == S_IDLE && !req_on_i && !req_off_i) |-> ##1 (st == S_IDLE))
        else $error("button started a timed press");

endmodule

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;
    logic clk = 1'b0;
    logic rst_n, tick_i, init_done_i, secure_i, pwr_good_i, btn_raw_i, s5_raw_i;
    logic req_on_i, req_off_i, fault_clr_i;
    logic chip_btn_o, pwr_en_o, fault_up_o, fault_dn_o, s5_o, s5_evt_o;
    logic [1:0] state_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_top #(.TICK_DIV(2), .UP_UNITS(10), .DN_UNITS(4),
                  .BTN_UNITS(5), .S5_UNITS(3)) i_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .init_done_i(init_done_i),
        .secure_i(secure_i), .pwr_good_i(pwr_good_i), .btn_raw_i(btn_raw_i),
        .s5_raw_i(s5_raw_i), .req_on_i(req_on_i), .req_off_i(req_off_i),
        .fault_clr_i(fault_clr_i), .chip_btn_o(chip_btn_o), .pwr_en_o(pwr_en_o),
        .fault_up_o(fault_up_o), .fault_dn_o(fault_dn_o), .s5_o(s5_o),
        .s5_evt_o(s5_evt_o), .state_o(state_o)
    );

    // vector fields: [9] direction (1 = power-up), [8:1] cycles until
    // power-good confirms (255 = never), [0] expected fault
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 8'd5,   1'b0},
        {1'b1, 8'd12,  1'b0},
        {1'b1, 8'd255, 1'b1},
        {1'b0, 8'd2,   1'b0},
        {1'b0, 8'd255, 1'b1},
        {1'b1, 8'd1,   1'b0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_on();
        req_on_i = 1'b1; cyc(1); req_on_i = 1'b0;
    endtask

    task automatic pulse_off();
        req_off_i = 1'b1; cyc(1); req_off_i = 1'b0;
    endtask

    task automatic pulse_clr();
        fault_clr_i = 1'b1; cyc(1); fault_clr_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b1; init_done_i = 1'b0; secure_i = 1'b0;
        pwr_good_i = 1'b0; btn_raw_i = 1'b0; s5_raw_i = 1'b0;
        req_on_i = 1'b0; req_off_i = 1'b0; fault_clr_i = 1'b0;
        cyc(3);
        chk("R1", "reset enable", pwr_en_o, 0);
        chk("R1", "reset state", state_o, 0);
        chk("R10", "reset s5", s5_o, 0);
        rst_n = 1'b1;
        cyc(2);

        // R6: requests ignored before init
        pulse_on();
        cyc(2);
        chk("R6", "pre-init state", state_o, 0);
        chk("R6", "pre-init button", chip_btn_o, 0);
        chk("R1", "enable before init", pwr_en_o, 0);

        init_done_i = 1'b1;
        cyc(1);
        chk("R1", "enable after init", pwr_en_o, 1);
        chk("R1", "idle after init", state_o, 1);
        init_done_i = 1'b0;
        cyc(3);
        chk("R1", "enable sticky", pwr_en_o, 1);

        // table-driven press sequences (R2..R5)
        for (int i = 0; i < 6; i++) begin
            logic       up;
            logic [7:0] dly;
            logic       fexp;
            string      rq, rt;
            up = VEC[i][9]; dly = VEC[i][8:1]; fexp = VEC[i][0];
            rq = up ? "R2" : "R4";
            rt = up ? "R3" : "R5";
            pwr_good_i = !up;
            cyc(2);
            pulse_clr();
            if (up) pulse_on(); else pulse_off();
            chk(rq, "press state", state_o, up ? 2 : 3);
            chk(rq, "press drive", chip_btn_o, 1);
            if (dly != 8'd255) begin
                cyc(dly);
                chk(rq, "still pressing", state_o, up ? 2 : 3);
                pwr_good_i = up;
                cyc(1);
                chk(rq, "confirmed idle", state_o, 1);
                chk(rq, "drive released", chip_btn_o, 0);
                chk(rt, "no fault", up ? fault_up_o : fault_dn_o, 0);
            end else begin
                cyc(up ? 14 : 4);
                chk(rt, "no early timeout", state_o, up ? 2 : 3);
                chk(rt, "no early fault", up ? fault_up_o : fault_dn_o, 0);
                cyc(20);
                chk(rt, "timeout idle", state_o, 1);
                chk(rt, "timeout fault", up ? fault_up_o : fault_dn_o, fexp);
                chk(rt, "timeout released", chip_btn_o, 0);
            end
        end

        // R7: sticky fault and clear
        pulse_clr();
        pwr_good_i = 1'b0;
        pulse_on();
        cyc(30);
        chk("R7", "fault set", fault_up_o, 1);
        cyc(10);
        chk("R7", "fault holds", fault_up_o, 1);
        pulse_clr();
        chk("R7", "fault cleared", fault_up_o, 0);

        // R6: second request during a press ignored
        pulse_on();
        cyc(2);
        pulse_off();
        cyc(1);
        chk("R6", "busy ignores request", state_o, 2);
        cyc(30);
        chk("R6", "busy ends idle", state_o, 1);
        pulse_clr();

        // R12: no ticks, no timeout
        tick_i = 1'b0;
        pulse_on();
        cyc(40);
        chk("R12", "frozen window", state_o, 2);
        chk("R12", "frozen no fault", fault_up_o, 0);
        tick_i = 1'b1;
        cyc(30);
        chk("R12", "window resumes", fault_up_o, 1);
        pulse_clr();

        // R8: glitch shorter than hold
        begin
            int seen = 0;
            btn_raw_i = 1'b1;
            for (int k = 0; k < 6; k++) begin cyc(1); if (chip_btn_o) seen++; end
            btn_raw_i = 1'b0;
            for (int k = 0; k < 20; k++) begin cyc(1); if (chip_btn_o) seen++; end
            chk("R8", "glitch ignored", seen, 0);
        end
        btn_raw_i = 1'b1;
        cyc(6);
        chk("R8", "not yet qualified", chip_btn_o, 0);
        cyc(20);
        chk("R8", "qualified press", chip_btn_o, 1);
        chk("R8", "no timed press", state_o, 1);

        // R9: lockout
        secure_i = 1'b1;
        cyc(1);
        chk("R9", "button locked", chip_btn_o, 0);
        secure_i = 1'b0;
        cyc(1);
        chk("R9", "button unlocked", chip_btn_o, 1);
        btn_raw_i = 1'b0;
        cyc(25);
        chk("R8", "release qualified", chip_btn_o, 0);
        secure_i = 1'b1;
        pwr_good_i = 1'b0;
        pulse_on();
        cyc(1);
        chk("R9", "sequence locked", chip_btn_o, 0);
        chk("R9", "sequence running", state_o, 2);
        secure_i = 1'b0;
        cyc(1);
        chk("R9", "sequence unlocked", chip_btn_o, 1);
        pwr_good_i = 1'b1;
        cyc(2);
        chk("R2", "locked run confirmed", state_o, 1);

        // R10/R11: S5 qualification and events
        begin
            int ev = 0;
            s5_raw_i = 1'b1;
            for (int k = 0; k < 3; k++) begin cyc(1); if (s5_evt_o) ev++; end
            s5_raw_i = 1'b0;
            for (int k = 0; k < 20; k++) begin cyc(1); if (s5_evt_o) ev++; end
            chk("R10", "s5 glitch level", s5_o, 0);
            chk("R11", "s5 glitch events", ev, 0);
            ev = 0;
            s5_raw_i = 1'b1;
            cyc(3);
            chk("R10", "s5 not yet", s5_o, 0);
            for (int k = 0; k < 20; k++) begin cyc(1); if (s5_evt_o) ev++; end
            chk("R10", "s5 qualified", s5_o, 1);
            chk("R11", "one rise event", ev, 1);
            ev = 0;
            s5_raw_i = 1'b0;
            for (int k = 0; k < 20; k++) begin cyc(1); if (s5_evt_o) ev++; end
            chk("R10", "s5 low qualified", s5_o, 0);
            chk("R11", "one fall event", ev, 1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule